// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It runs a fixed set of nine instructions: five register-to-register operations (add, sub, and, or, set-on-less-than), a word load, a word store, a branch taken when two registers are equal, and an unconditional jump. The program sits in an internal instruction store and the data in a separate internal data store, so an instruction fetch and a data access can both happen within the same cycle. The verification environment fills both stores directly before it releases reset.

The datapath reads the register file combinationally. The ALU computes either a result or an address. The load, store and register write all commit on the rising edge that ends the cycle. Program-counter sequencing does not use the ALU. A dedicated incrementer forms PC+4, and a second adder forms the branch target. The jump target is spliced together from PC+4 and the instruction's 26-bit field. A debug view shows the address of the instruction now executing and the register write it will commit at the next edge.

Top module: `scc_core`

## Requirements
- R1: While rst_n is low, the PC reads 0 and no register or memory write takes place. The first instruction after release is fetched from byte address 0.
- R2: Any instruction that is neither a taken branch nor a jump advances the PC by exactly 4.
- R3: Register 0 always reads as zero. A write aimed at register 0 is dropped and is not shown on dbg_wr_en.
- R4: Opcode 0x00 is the register format, with rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11. It writes rd with rs+rt for funct 0x20, rs-rt for 0x22, rs AND rt for 0x24 and rs OR rt for 0x25. The next instruction sees the new value.
- R5: Register format with funct 0x2A writes rd with 1 when rs is less than rt as signed 32-bit values, and with 0 otherwise.
- R6: Opcode 0x23 loads the data word at rs plus the sign-extended bits 15:0 into rt. With rs = register 0 this gives an absolute address.
- R7: Opcode 0x2B stores rt at rs plus the sign-extended bits 15:0 and writes no register. A later load from that address returns the stored word.
- R8: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2, and negative offsets branch backwards. Otherwise the next PC is PC+4. No register is written.
- R9: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits. No register is written.
- R10: An unrecognised opcode, or a register-format word with an unrecognised funct (the all-zero word included), writes no register and no memory and advances the PC by 4.
- R11: dbg_pc shows the address of the instruction executing in the current cycle. dbg_wr_en, dbg_wr_addr and dbg_wr_data show the register write that commits at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write commits at the end of this cycle |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The bench builds the core with a 64-word instruction store and a 32-word data store. The 64-word store holds straight-line code, forward and backward branches, and jumps in both directions within one program. The 32-word data store keeps every load and store address, including those formed from a negative displacement off a base register, on distinct in-range words. Because of those sizes, a single short program can check jump targets that land on earlier code, a branch that goes back to an instruction that then jumps forward, and a store followed by a load of the same word.

// File: rtl/scc_pkg.sv
package scc_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned NREGS    = 32;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned JFIELD_W = 26;

  // primary opcodes, bits 31:26
  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;

  // function codes, bits 5:0 of register-format words
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_dst;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
  import scc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  alu_cls_e cls;
  alu_op_e  funct_op;
  logic     funct_ok;

  // second-level decode: function field to ALU operation
  always_comb begin
    funct_ok = 1'b1;
    case (funct)
      FN_ADD:  funct_op = ALU_ADD;
      FN_SUB:  funct_op = ALU_SUB;
      FN_AND:  funct_op = ALU_AND;
      FN_OR:   funct_op = ALU_OR;
      FN_SLT:  funct_op = ALU_SLT;
      default: begin
        funct_op = ALU_ADD;
        funct_ok = 1'b0;
      end
    endcase
  end

  // first-level decode: opcode to control set and ALU class
  always_comb begin
    ctrl = '0;
    cls  = CLS_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_write = funct_ok;
        cls            = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STOR: begin
        ctrl.mem_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        cls         = CLS_SUB;
      end
      OPC_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
    case (cls)
      CLS_SUB:   ctrl.alu_op = ALU_SUB;
      CLS_FUNCT: ctrl.alu_op = funct_op;
      default:   ctrl.alu_op = ALU_ADD;
    endcase
  end

  // R10
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_write, ctrl.mem_write, ctrl.branch, ctrl.jump}));

  // R6
  load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_to_reg |-> (ctrl.mem_read && ctrl.alu_src && ctrl.alu_op == ALU_ADD));

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr1,
  input  logic [AW-1:0]    raddr2,
  output logic [WIDTH-1:0] rdata1,
  output logic [WIDTH-1:0] rdata2,
  output logic             wr_commit
);

  logic [WIDTH-1:0] regs_q [NREGS];

  // writes to entry zero are dropped
  assign wr_commit = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_commit) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata1 = (raddr1 == '0) ? '0 : regs_q[raddr1];
  assign rdata2 = (raddr2 == '0) ? '0 : regs_q[raddr2];

  // R4
  rf_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (raddr1 != $past(waddr) || rdata1 == $past(wdata)));

  // R3
  rf_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr2 == '0) |-> (rdata2 == '0));

endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y,
  output logic             zero
);

  logic signed_lt;

  assign signed_lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, signed_lt};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/scc_mem.sv
module scc_mem #(
  parameter int WORDS    = 64,
  parameter int WIDTH    = 32,
  parameter bit WRITABLE = 1'b1,
  parameter int IW       = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem_q [WORDS];

  assign rdata = re ? mem_q[idx] : '0;

  generate
    if (WRITABLE) begin : g_ram
      always_ff @(posedge clk) begin
        if (we) begin
          mem_q[idx] <= wdata;
        end
      end

      // R7
      store_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (!(re && idx == $past(idx)) || rdata == $past(wdata)));
    end else begin : g_rom
      logic unused_wr;
      assign unused_wr = ^{we, wdata, clk, rst_n};

      // contents are filled from outside before reset is released
      initial begin
        for (int i = 0; i < WORDS; i++) begin
          mem_q[i] = '0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter logic [31:0] RESET_PC   = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_addr,
  output logic [31:0] dbg_wr_data
);

  localparam int IIW = $clog2(IMEM_WORDS);
  localparam int DIW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_d, pc_inc, br_tgt, j_tgt;
  logic [XLEN-1:0]   instr, imm_ext, imm_shl;
  logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, wr_addr;
  logic [5:0]        op_f, fn_f;
  ctrl_t             ctrl;
  logic              alu_zero, pc_src, rf_we, dm_we, wr_commit;

  // ---------------- fetch ----------------
  scc_mem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN), .WRITABLE(1'b0)) u_imem (
    .clk   (clk),
    .rst_n (rst_n),
    .re    (1'b1),
    .we    (1'b0),
    .idx   (pc_q[IIW+1:2]),
    .wdata ('0),
    .rdata (instr)
  );

  assign op_f = instr[31:26];
  assign rs_f = instr[25:21];
  assign rt_f = instr[20:16];
  assign rd_f = instr[15:11];
  assign fn_f = instr[5:0];

  // ---------------- decode ----------------
  scc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (op_f),
    .funct  (fn_f),
    .ctrl   (ctrl)
  );

  assign imm_ext = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign wr_addr = ctrl.reg_dst ? rd_f : rt_f;
  assign rf_we   = ctrl.reg_write & rst_n;
  assign dm_we   = ctrl.mem_write & rst_n;

  scc_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (rf_we),
    .waddr     (wr_addr),
    .wdata     (wb_data),
    .raddr1    (rs_f),
    .raddr2    (rt_f),
    .rdata1    (rs_val),
    .rdata2    (rt_val),
    .wr_commit (wr_commit)
  );

  // ---------------- execute ----------------
  assign alu_b = ctrl.alu_src ? imm_ext : rt_val;

  scc_alu #(.WIDTH(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // ---------------- memory ----------------
  scc_mem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN), .WRITABLE(1'b1)) u_dmem (
    .clk   (clk),
    .rst_n (rst_n),
    .re    (ctrl.mem_read),
    .we    (dm_we),
    .idx   (alu_y[DIW+1:2]),
    .wdata (rt_val),
    .rdata (mem_rd)
  );

  assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;

  // ---------------- next PC ----------------
  // dedicated incrementer and branch-target adder, independent of the ALU
  assign pc_inc  = pc_q + 32'd4;
  assign imm_shl = {imm_ext[XLEN-3:0], 2'b00};
  assign br_tgt  = pc_inc + imm_shl;
  assign j_tgt   = {pc_inc[XLEN-1:XLEN-4], instr[JFIELD_W-1:0], 2'b00};
  assign pc_src  = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump) begin
      pc_d = j_tgt;
    end else if (pc_src) begin
      pc_d = br_tgt;
    end else begin
      pc_d = pc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= pc_d;
    end
  end

  // ---------------- debug view ----------------
  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wr_commit;
  assign dbg_wr_addr = wr_addr;
  assign dbg_wr_data = wb_data;

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.jump && !pc_src) |=> (pc_q == $past(pc_q) + 32'd4));

  // R8
  beq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.branch && rs_val != rt_val) |=> (pc_q == $past(pc_q) + 32'd4));

  // R9
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jump |=> (pc_q[31:28] == $past(pc_inc[31:28]) && !$past(wr_commit)));

  // R3
  zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_f == '0) |-> (rs_val == '0));

endmodule

// File: tb/scc_core_tb_top.sv
`timescale 1ns/1ps
module scc_core_tb_top;

  localparam int IMW = 64;
  localparam int DMW = 32;

  localparam logic [5:0] T_LOAD = 6'h23;
  localparam logic [5:0] T_STOR = 6'h2B;
  localparam logic [5:0] T_BEQ  = 6'h04;
  localparam logic [5:0] F_ADD  = 6'h20;
  localparam logic [5:0] F_SUB  = 6'h22;
  localparam logic [5:0] F_AND  = 6'h24;
  localparam logic [5:0] F_OR   = 6'h25;
  localparam logic [5:0] F_SLT  = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  scc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic put_i(input int idx, input logic [31:0] w);
    dut_i.u_imem.mem_q[idx] = w;
  endtask

  task automatic put_d(input int idx, input logic [31:0] w);
    dut_i.u_dmem.mem_q[idx] = w;
  endtask

  // enter reset and blank the program store (all-zero word is a no-op)
  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IMW; i++) put_i(i, 32'h0);
  endtask

  task automatic release_reset();
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 32'h0);
    chk(dbg_wr_en == 1'b0, "R1", "write in reset", {31'd0, dbg_wr_en}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic step(input logic [31:0] epc, input bit ewe, input logic [4:0] ea,
                      input logic [31:0] ed, input string req);
    chk(dbg_pc == epc, req, "pc", dbg_pc, epc);
    chk(dbg_wr_en == ewe, req, "wr_en", {31'd0, dbg_wr_en}, {31'd0, ewe});
    if (ewe) begin
      chk(dbg_wr_addr == ea, req, "wr_addr", {27'd0, dbg_wr_addr}, {27'd0, ea});
      chk(dbg_wr_data == ed, req, "wr_data", dbg_wr_data, ed);
    end
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic test_reset_and_alu();
    begin_test();
    put_d(0, 32'd100);
    put_d(1, 32'hFFFF_FFF0);
    put_d(2, 32'h0F0F_00FF);
    put_i(0, enc_i(T_LOAD, 5'd0, 5'd1, 16'd0));
    put_i(1, enc_i(T_LOAD, 5'd0, 5'd2, 16'd4));
    put_i(2, enc_i(T_LOAD, 5'd0, 5'd3, 16'd8));
    put_i(3, enc_r(5'd1, 5'd2, 5'd4, F_ADD));
    put_i(4, enc_r(5'd1, 5'd2, 5'd5, F_SUB));
    put_i(5, enc_r(5'd3, 5'd2, 5'd6, F_AND));
    put_i(6, enc_r(5'd3, 5'd2, 5'd7, F_OR));
    put_i(7, enc_r(5'd2, 5'd1, 5'd8, F_SLT));
    put_i(8, enc_r(5'd1, 5'd2, 5'd9, F_SLT));
    put_i(9, enc_i(T_LOAD, 5'd1, 5'd10, 16'hFFA0));
    release_reset();
    step(32'd0,  1'b1, 5'd1,  32'd100,        "R6");
    step(32'd4,  1'b1, 5'd2,  32'hFFFF_FFF0,  "R6");
    step(32'd8,  1'b1, 5'd3,  32'h0F0F_00FF,  "R2");
    step(32'd12, 1'b1, 5'd4,  32'd84,         "R4");
    step(32'd16, 1'b1, 5'd5,  32'd116,        "R4");
    step(32'd20, 1'b1, 5'd6,  32'h0F0F_00F0,  "R4");
    step(32'd24, 1'b1, 5'd7,  32'hFFFF_FFFF,  "R4");
    step(32'd28, 1'b1, 5'd8,  32'd1,          "R5");
    step(32'd32, 1'b1, 5'd9,  32'd0,          "R5");
    step(32'd36, 1'b1, 5'd10, 32'hFFFF_FFF0,  "R6");
    step(32'd40, 1'b0, 5'd0,  32'd0,          "R11");
  endtask

  task automatic test_zero_reg();
    begin_test();
    put_d(0, 32'd100);
    put_i(0, enc_i(T_LOAD, 5'd0, 5'd1, 16'd0));
    put_i(1, enc_r(5'd1, 5'd1, 5'd0, F_ADD));
    put_i(2, enc_r(5'd0, 5'd1, 5'd12, F_ADD));
    put_i(3, enc_i(T_LOAD, 5'd0, 5'd0, 16'd0));
    put_i(4, enc_r(5'd0, 5'd0, 5'd13, F_OR));
    release_reset();
    step(32'd0,  1'b1, 5'd1,  32'd100, "R6");
    step(32'd4,  1'b0, 5'd0,  32'd0,   "R3");
    step(32'd8,  1'b1, 5'd12, 32'd100, "R3");
    step(32'd12, 1'b0, 5'd0,  32'd0,   "R3");
    step(32'd16, 1'b1, 5'd13, 32'd0,   "R3");
  endtask

  task automatic test_store();
    begin_test();
    put_d(0, 32'd100);
    put_d(5, 32'hDEAD_0005);
    put_d(6, 32'hDEAD_0006);
    put_i(0, enc_i(T_LOAD, 5'd0, 5'd1, 16'd0));
    put_i(1, enc_i(T_STOR, 5'd0, 5'd1, 16'd20));
    put_i(2, enc_i(T_LOAD, 5'd0, 5'd14, 16'd20));
    put_i(3, enc_i(T_STOR, 5'd1, 5'd1, 16'hFFB4));
    put_i(4, enc_i(T_LOAD, 5'd0, 5'd15, 16'd24));
    release_reset();
    step(32'd0,  1'b1, 5'd1,  32'd100, "R6");
    step(32'd4,  1'b0, 5'd0,  32'd0,   "R7");
    step(32'd8,  1'b1, 5'd14, 32'd100, "R7");
    step(32'd12, 1'b0, 5'd0,  32'd0,   "R7");
    step(32'd16, 1'b1, 5'd15, 32'd100, "R7");
  endtask

  task automatic test_branch();
    begin_test();
    put_d(0, 32'd100);
    put_i(0,  enc_i(T_LOAD, 5'd0, 5'd1, 16'd0));
    put_i(1,  enc_i(T_LOAD, 5'd0, 5'd2, 16'd0));
    put_i(2,  enc_i(T_BEQ,  5'd1, 5'd2, 16'd3));
    put_i(3,  enc_j(26'd10));
    put_i(4,  enc_r(5'd1, 5'd1, 5'd20, F_ADD));
    put_i(5,  enc_r(5'd1, 5'd1, 5'd20, F_ADD));
    put_i(6,  enc_i(T_BEQ,  5'd1, 5'd0, 16'd5));
    put_i(7,  enc_i(T_BEQ,  5'd0, 5'd0, 16'hFFFB));
    put_i(10, enc_r(5'd1, 5'd2, 5'd16, F_ADD));
    release_reset();
    step(32'd0,  1'b1, 5'd1,  32'd100, "R6");
    step(32'd4,  1'b1, 5'd2,  32'd100, "R6");
    step(32'd8,  1'b0, 5'd0,  32'd0,   "R8");
    step(32'd24, 1'b0, 5'd0,  32'd0,   "R8");
    step(32'd28, 1'b0, 5'd0,  32'd0,   "R8");
    step(32'd12, 1'b0, 5'd0,  32'd0,   "R9");
    step(32'd40, 1'b1, 5'd16, 32'd200, "R9");
    step(32'd44, 1'b0, 5'd0,  32'd0,   "R2");
  endtask

  task automatic test_jump();
    begin_test();
    put_i(0, enc_j(26'd3));
    put_i(1, enc_r(5'd0, 5'd0, 5'd17, F_ADD));
    put_i(3, enc_j(26'd1));
    release_reset();
    step(32'd0,  1'b0, 5'd0,  32'd0, "R9");
    step(32'd12, 1'b0, 5'd0,  32'd0, "R9");
    step(32'd4,  1'b1, 5'd17, 32'd0, "R9");
    step(32'd8,  1'b0, 5'd0,  32'd0, "R10");
  endtask

  task automatic test_unknown();
    begin_test();
    put_d(0, 32'd100);
    put_d(5, 32'h0000_1234);
    put_i(0, enc_i(T_LOAD, 5'd0, 5'd1, 16'd0));
    put_i(1, 32'hFC22_0000);
    put_i(2, enc_r(5'd1, 5'd1, 5'd5, 6'h07));
    put_i(3, enc_i(6'h2A, 5'd0, 5'd1, 16'd20));
    put_i(4, enc_i(T_LOAD, 5'd0, 5'd18, 16'd20));
    release_reset();
    step(32'd0,  1'b1, 5'd1,  32'd100,        "R6");
    step(32'd4,  1'b0, 5'd0,  32'd0,          "R10");
    step(32'd8,  1'b0, 5'd0,  32'd0,          "R10");
    step(32'd12, 1'b0, 5'd0,  32'd0,          "R10");
    step(32'd16, 1'b1, 5'd18, 32'h0000_1234,  "R10");
    step(32'd20, 1'b0, 5'd0,  32'd0,          "R2");
  endtask

  initial begin
    test_reset_and_alu();
    test_zero_reg();
    test_store();
    test_branch();
    test_jump();
    test_unknown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule